// File: doc/BRIEF.md
# Byte-Wide Storage with Calendar Clock

This block is a byte-wide, SRAM-style store with a calendar clock folded into its top eight locations. All the lower locations are plain read/write bytes. The eight top locations are holding bytes. They are not the counters themselves. Separate BCD counters keep seconds, minutes, 24-hour hours, day of week, date, month and two-digit year. The counters are copied into the holding bytes once per second, and the host reads and writes those bytes with the same cycles it uses for any other address.

A slow clock enable (`tick_en`, nominally 32768 pulses per second) is divided by `TICK_DIV` to form the one-second step. The first top location is a control byte. Its bits freeze the holding bytes so a multi-byte read sees a consistent snapshot, hold host-written time until it is committed to the counters, or stop the clock. The control byte also keeps a five-bit calibration value, which is stored only. When `pwr_ok` is low, every write is refused.

The default address width is 11 bits, which keeps elaboration small. `ADDR_W = 13` gives the full 8K map. The clock always sits at the top eight addresses of whatever space is chosen.

Top module: `rtc_sram`

## Requirements
- R1: A write (selected, `we_n` low, `pwr_ok` high, sampled at a rising `clk`) to any address below the top eight stores `wdata`. A later read of that address returns the byte.
- R2: The part is selected only when `ce_n` is 0 and `ce` is 1. `rdata_en` is 1 only when selected with `oe_n` 0 and `we_n` 1. Otherwise `rdata_en` is 0 and `rdata` reads 00h.
- R3: While `pwr_ok` is 0, writes change neither the ordinary storage nor any clock byte.
- R4: Clock byte offsets from the top-eight base are 0 control, 1 seconds, 2 minutes, 3 hours (00–23), 4 day of week (1–7), 5 date, 6 month, 7 year, all in packed BCD. Each second the counters step by one, with 59→00 carries, 23→00 into the date, and day of week 7→1.
- R5: The date wraps to 01 after 31 in Jan/Mar/May/Jul/Aug/Oct/Dec, after 30 in Apr/Jun/Sep/Nov, and after 28 in February. February instead runs to 29 when the year is divisible by four.
- R6: Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R7: One second is `TICK_DIV` cycles with `tick_en` high. The holding bytes take the counter values one cycle after each second step.
- R8: While control bit 6 is 1, the per-second copy into the holding bytes is suppressed, and the counters keep running.
- R9: While control bit 7 is 1, host-written clock bytes are not overwritten. A control write that clears bit 7 loads the holding bytes into the counters and restarts the sub-second divider, so the next step comes `TICK_DIV` enabled cycles later.
- R10: While control bit 5 is 1, the one-second step does not occur.
- R11: All eight control bits read back as written. The low five bits (calibration) have no effect on timekeeping.
- R12: After reset, the control byte is 00h and the time reads 00:00:00, day 1, date 01, month 01, year 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Slow time-base enable, one pulse per oscillator period |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| ce_n | input | 1 | Active-low chip enable |
| ce | input | 1 | Active-high chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| pwr_ok | input | 1 | Supply within tolerance; low blocks writes |
| rdata | output | 8 | Read data, 00h when not driven |
| rdata_en | output | 1 | Read data valid; low means bus released |

## Verification
The calendar step is exercised from fixed corner dates and from random dates whose expected successor is computed by integer arithmetic in the bench. The fixed dates are year end, February in leap and common years, a 30-day month and a 31-day month. Together they separate a carry error in each field from an error in the month-length table. Ordinary storage is filled at random addresses and read back, which shows the clock window does not alias onto the storage. The control bits are each tried on their own with reads placed inside known seconds. A frozen read that still changes, a stopped clock that still counts, or a held write that gets overwritten each gives a value distinct from the correct one.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int NFIELD    = 7;
   localparam int IDX_SEC   = 0;
   localparam int IDX_MIN   = 1;
   localparam int IDX_HOUR  = 2;
   localparam int IDX_DAY   = 3;
   localparam int IDX_DATE  = 4;
   localparam int IDX_MONTH = 5;
   localparam int IDX_YEAR  = 6;

   localparam int CTL_HOLD_BIT   = 7;
   localparam int CTL_FREEZE_BIT = 6;
   localparam int CTL_STOP_BIT   = 5;

   typedef logic [NFIELD-1:0][7:0] rtc_time_t;

   // {year, month, date, day, hour, min, sec}
   localparam rtc_time_t TIME_RST = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
   endfunction

   // divisible by four: even tens with ones 0/4/8, odd tens with ones 2/6
   function automatic logic is_leap(input logic [7:0] y);
      if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
   endfunction

   function automatic logic [7:0] last_date(input logic [7:0] m, input logic [7:0] y);
      case (m)
         8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic stop,
   input  logic clear,
   output logic sec_tick
);
   localparam int  CW   = (DIV > 1) ? $clog2(DIV) : 1;
   localparam bit  POW2 = ((DIV & (DIV - 1)) == 0);

   logic [CW-1:0] cnt_q;
   logic          at_end;

   generate
      if (DIV < 2) begin : g_bad_div
         $error("rtc_prescaler: DIV must be at least 2");
      end
      if (POW2) begin : g_wrap
         assign at_end = &cnt_q;
      end else begin : g_cmp
         assign at_end = (cnt_q == CW'(DIV - 1));
      end
   endgenerate

   assign sec_tick = tick_en & ~stop & ~clear & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (clear)            cnt_q <= '0;
      else if (tick_en && !stop) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sec_tick,
   input  logic      load,
   input  rtc_time_t load_val,
   output rtc_time_t cur
);
   rtc_time_t cur_q, nxt;

   always_comb begin
      nxt = cur_q;
      if (cur_q[IDX_SEC] != 8'h59) begin
         nxt[IDX_SEC] = bcd_inc(cur_q[IDX_SEC]);
      end else begin
         nxt[IDX_SEC] = 8'h00;
         if (cur_q[IDX_MIN] != 8'h59) begin
            nxt[IDX_MIN] = bcd_inc(cur_q[IDX_MIN]);
         end else begin
            nxt[IDX_MIN] = 8'h00;
            if (cur_q[IDX_HOUR] != 8'h23) begin
               nxt[IDX_HOUR] = bcd_inc(cur_q[IDX_HOUR]);
            end else begin
               nxt[IDX_HOUR] = 8'h00;
               nxt[IDX_DAY]  = (cur_q[IDX_DAY] == 8'h07) ? 8'h01 : bcd_inc(cur_q[IDX_DAY]);
               if (cur_q[IDX_DATE] != last_date(cur_q[IDX_MONTH], cur_q[IDX_YEAR])) begin
                  nxt[IDX_DATE] = bcd_inc(cur_q[IDX_DATE]);
               end else begin
                  nxt[IDX_DATE] = 8'h01;
                  if (cur_q[IDX_MONTH] != 8'h12) begin
                     nxt[IDX_MONTH] = bcd_inc(cur_q[IDX_MONTH]);
                  end else begin
                     nxt[IDX_MONTH] = 8'h01;
                     nxt[IDX_YEAR]  = (cur_q[IDX_YEAR] == 8'h99) ? 8'h00 : bcd_inc(cur_q[IDX_YEAR]);
                  end
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cur_q <= TIME_RST;
      else if (load)     cur_q <= load_val;
      else if (sec_tick) cur_q <= nxt;
   end

   assign cur = cur_q;
endmodule

// File: rtl/rtc_holding.sv
module rtc_holding
   import rtc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] wr_ofs,
   input  logic [7:0] wr_data,
   input  logic       copy,
   input  rtc_time_t  cur,
   output logic [7:0] ctrl,
   output rtc_time_t  hold
);
   logic [7:0] ctrl_q;
   logic [7:0] byte_q [NFIELD];
   logic       freeze;

   assign freeze = ctrl_q[CTL_FREEZE_BIT] | ctrl_q[CTL_HOLD_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         ctrl_q <= 8'h00;
      else if (wr_en && wr_ofs == 3'd0)   ctrl_q <= wr_data;
   end

   generate
      for (genvar i = 0; i < NFIELD; i++) begin : g_byte
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               byte_q[i] <= TIME_RST[i];
            else if (wr_en && wr_ofs == 3'(i + 1))    byte_q[i] <= wr_data;
            else if (copy && !freeze)                 byte_q[i] <= cur[i];
         end
      end
   endgenerate

   always_comb begin
      for (int k = 0; k < NFIELD; k++) hold[k] = byte_q[k];
   end

   assign ctrl = ctrl_q;
endmodule

// File: rtl/rtc_store.sv
module rtc_store #(
   parameter int AW    = 11,
   parameter int DEPTH = 2040
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);
   generate
      if (DEPTH > (1 << AW)) begin : g_bad_depth
         $error("rtc_store: DEPTH exceeds address space");
      end
   endgenerate

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/rtc_sram.sv
module rtc_sram
   import rtc_pkg::*;
#(
   parameter int ADDR_W   = 11,
   parameter int TICK_DIV = 32768
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic              ce_n,
   input  logic              ce,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              pwr_ok,
   output logic [7:0]        rdata,
   output logic              rdata_en
);
   localparam int CLK_BYTES = 8;
   localparam int OFS_W     = $clog2(CLK_BYTES);
   localparam int RAM_DEPTH = (1 << ADDR_W) - CLK_BYTES;

   generate
      if (ADDR_W < 4 || ADDR_W > 16) begin : g_bad_aw
         $error("rtc_sram: ADDR_W must lie in 4..16");
      end
   endgenerate

   logic             sel, hit_clk, wr, ram_we, reg_we, load;
   logic             sec_tick, copy_q;
   logic [OFS_W-1:0] ofs, ofs_m1;
   logic [7:0]       ctrl, ram_rd, clk_rd;
   rtc_time_t        hold, cur;

   assign sel     = ~ce_n & ce;
   assign hit_clk = &addr[ADDR_W-1:OFS_W];
   assign ofs     = addr[OFS_W-1:0];
   assign ofs_m1  = ofs - 1'b1;
   assign wr      = sel & ~we_n & pwr_ok;
   assign ram_we  = wr & ~hit_clk;
   assign reg_we  = wr & hit_clk;
   assign load    = reg_we & (ofs == '0) & ctrl[CTL_HOLD_BIT] & ~wdata[CTL_HOLD_BIT];

   rtc_store #(.AW(ADDR_W), .DEPTH(RAM_DEPTH)) u_store (
      .clk(clk), .we(ram_we), .addr(addr), .wdata(wdata), .rdata(ram_rd)
   );

   rtc_prescaler #(.DIV(TICK_DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .stop(ctrl[CTL_STOP_BIT]), .clear(load), .sec_tick(sec_tick)
   );

   rtc_calendar u_cal (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
      .load(load), .load_val(hold), .cur(cur)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) copy_q <= 1'b0;
      else        copy_q <= sec_tick;
   end

   rtc_holding u_hold (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_ofs(ofs),
      .wr_data(wdata), .copy(copy_q), .cur(cur), .ctrl(ctrl), .hold(hold)
   );

   assign clk_rd   = (ofs == '0) ? ctrl : hold[ofs_m1];
   assign rdata_en = sel & ~oe_n & we_n;
   assign rdata    = rdata_en ? (hit_clk ? clk_rd : ram_rd) : 8'h00;
endmodule

// File: rtl/rtc_sram_chk.sv
module rtc_sram_chk
   import rtc_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       ce_n,
   input logic       ce,
   input logic       pwr_ok,
   input logic       rdata_en,
   input logic       reg_we,
   input logic       load,
   input logic       sec_tick,
   input logic [7:0] ctrl,
   input rtc_time_t  hold,
   input rtc_time_t  cur
);
   // R2
   deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || !ce) |-> !rdata_en);

   // R3
   pwr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_ok |=> $stable(ctrl));

   // R4
   sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !load && cur[IDX_SEC] == 8'h59) |=> (cur[IDX_SEC] == 8'h00));

   // R8
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[CTL_FREEZE_BIT] && !reg_we) |=> $stable(hold));

   // R9
   commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cur == $past(hold)));

   // R10
   stop_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[CTL_STOP_BIT] |-> !sec_tick);
endmodule

bind rtc_sram rtc_sram_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce(ce), .pwr_ok(pwr_ok),
   .rdata_en(rdata_en), .reg_we(reg_we), .load(load), .sec_tick(sec_tick),
   .ctrl(ctrl), .hold(hold), .cur(cur)
);

// File: tb/rtc_sram_tb.sv
module rtc_sram_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW         = 11;
   localparam int DIV        = 8;
   localparam int TOP        = (1 << AW) - 8;

   logic          clk = 0, rst_n = 0, tick_en = 0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic          ce_n = 1, ce = 0, oe_n = 1, we_n = 1, pwr_ok = 1;
   logic [7:0]    rdata;
   logic          rdata_en;

   int n_chk = 0, n_err = 0;
   logic [7:0] mdl [1 << AW];

   always #(CLK_PERIOD / 2) clk = ~clk;

   rtc_sram #(.ADDR_W(AW), .TICK_DIV(DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr), .wdata(wdata),
      .ce_n(ce_n), .ce(ce), .oe_n(oe_n), .we_n(we_n), .pwr_ok(pwr_ok),
      .rdata(rdata), .rdata_en(rdata_en)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input int a, input logic [7:0] d);
      @(negedge clk);
      addr = AW'(a); wdata = d; ce_n = 0; ce = 1; oe_n = 1; we_n = 0;
      @(posedge clk);
      #1;
      ce_n = 1; we_n = 1;
   endtask

   task automatic bus_read_sel(input int a, input logic cen, input logic cep,
                               input logic oen, output logic [7:0] d, output logic en);
      @(negedge clk);
      addr = AW'(a); ce_n = cen; ce = cep; oe_n = oen; we_n = 1;
      #1;
      d = rdata; en = rdata_en;
      ce_n = 1; ce = 0; oe_n = 1;
   endtask

   task automatic bus_read(input int a, output logic [7:0] d);
      logic en;
      bus_read_sel(a, 1'b0, 1'b1, 1'b0, d, en);
   endtask

   function automatic int b2i(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic logic [7:0] i2b(input int n);
      return {4'(n / 10), 4'(n % 10)};
   endfunction

   function automatic int month_days(input int mo, input int y);
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   // t = {year, month, date, day, hour, min, sec}
   function automatic logic [6:0][7:0] next_sec(input logic [6:0][7:0] t);
      int s, mi, h, dw, dt, mo, y;
      logic [6:0][7:0] r;
      s = b2i(t[0]); mi = b2i(t[1]); h = b2i(t[2]); dw = b2i(t[3]);
      dt = b2i(t[4]); mo = b2i(t[5]); y = b2i(t[6]);
      s++;
      if (s == 60) begin
         s = 0; mi++;
         if (mi == 60) begin
            mi = 0; h++;
            if (h == 24) begin
               h = 0; dw = (dw == 7) ? 1 : dw + 1; dt++;
               if (dt > month_days(mo, y)) begin
                  dt = 1; mo++;
                  if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
               end
            end
         end
      end
      r = {i2b(y), i2b(mo), i2b(dt), i2b(dw), i2b(h), i2b(mi), i2b(s)};
      return r;
   endfunction

   task automatic load_time(input logic [6:0][7:0] t, input logic [7:0] ctl_after);
      bus_write(TOP, 8'h80);
      for (int i = 0; i < 7; i++) bus_write(TOP + 1 + i, t[i]);
      bus_write(TOP, ctl_after);
   endtask

   // R4 R5 R6 R7: load, wait one second, freeze, compare every field
   task automatic step_case(input string req, input logic [6:0][7:0] t, input logic [7:0] ctl);
      logic [6:0][7:0] exp;
      logic [7:0] v;
      exp = next_sec(t);
      load_time(t, ctl);
      repeat (DIV + 1) @(posedge clk);
      bus_write(TOP, 8'h40);
      for (int i = 0; i < 7; i++) begin
         bus_read(TOP + 1 + i, v);
         chk(req, v, exp[i]);
      end
      bus_write(TOP, 8'h00);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic       en;
      logic [6:0][7:0] t;
      int a_list [40];
      void'($urandom(32'd20240607));

      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R12 reset state, read before any second has elapsed
      bus_read(TOP, v);     chk("R12 ctrl", v, 8'h00);
      bus_read(TOP + 1, v); chk("R12 sec", v, 8'h00);
      bus_read(TOP + 3, v); chk("R12 hour", v, 8'h00);
      bus_read(TOP + 4, v); chk("R12 day", v, 8'h01);
      bus_read(TOP + 5, v); chk("R12 date", v, 8'h01);
      bus_read(TOP + 6, v); chk("R12 month", v, 8'h01);
      bus_read(TOP + 7, v); chk("R12 year", v, 8'h00);
      tick_en = 1;

      // R1 random storage traffic
      for (int i = 0; i < 40; i++) begin
         a_list[i] = i * 50 + int'($urandom % 50);
         mdl[a_list[i]] = 8'($urandom);
         bus_write(a_list[i], mdl[a_list[i]]);
      end
      for (int i = 39; i >= 0; i--) begin
         bus_read(a_list[i], v);
         chk("R1 storage", v, mdl[a_list[i]]);
      end

      // R2 enables
      bus_read_sel(a_list[0], 1'b1, 1'b1, 1'b0, v, en);
      chk("R2 ce_n high en", {7'd0, en}, 8'h00); chk("R2 ce_n high data", v, 8'h00);
      bus_read_sel(a_list[0], 1'b0, 1'b0, 1'b0, v, en);
      chk("R2 ce low en", {7'd0, en}, 8'h00);
      bus_read_sel(a_list[0], 1'b0, 1'b1, 1'b1, v, en);
      chk("R2 oe_n high en", {7'd0, en}, 8'h00);
      bus_read_sel(a_list[0], 1'b0, 1'b1, 1'b0, v, en);
      chk("R2 selected en", {7'd0, en}, 8'h01);

      // R4 R5 R6 directed corners
      step_case("R6 year end",     {8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59}, 8'h00);
      step_case("R5 leap feb28",   {8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59}, 8'h00);
      step_case("R5 leap feb29",   {8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59}, 8'h00);
      step_case("R5 common feb28", {8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59}, 8'h00);
      step_case("R5 apr30",        {8'h25, 8'h04, 8'h30, 8'h05, 8'h23, 8'h59, 8'h59}, 8'h00);
      step_case("R4 plain",        {8'h25, 8'h01, 8'h31, 8'h03, 8'h12, 8'h34, 8'h56}, 8'h00);
      // R11 calibration bits set: timekeeping unchanged
      step_case("R11 cal no effect", {8'h25, 8'h07, 8'h15, 8'h06, 8'h09, 8'h59, 8'h59}, 8'h1F);

      // R4 R5 random dates
      for (int i = 0; i < 6; i++) begin
         int y, mo, d;
         y = int'($urandom % 100); mo = int'($urandom % 12) + 1;
         d = ($urandom % 2 == 0) ? month_days(mo, y) : int'($urandom % month_days(mo, y)) + 1;
         t = {i2b(y), i2b(mo), i2b(d), i2b(int'($urandom % 7) + 1),
              ($urandom % 2 == 0) ? 8'h23 : i2b(int'($urandom % 24)),
              ($urandom % 2 == 0) ? 8'h59 : i2b(int'($urandom % 60)), 8'h59};
         step_case("R4 R5 random", t, 8'h00);
      end

      // R8 freeze: counters keep running underneath
      load_time({8'h25, 8'h03, 8'h10, 8'h01, 8'h10, 8'h00, 8'h00}, 8'h40);
      repeat (4 * DIV) @(posedge clk);
      bus_read(TOP + 1, v); chk("R8 frozen sec", v, 8'h00);
      bus_write(TOP, 8'h00);
      repeat (DIV + 2) @(posedge clk);
      bus_read(TOP + 1, v); chk("R8 counting continued", v, 8'h05);

      // R9 held write survives, then commits
      bus_write(TOP, 8'h80);
      bus_write(TOP + 1, 8'h42);
      repeat (3 * DIV) @(posedge clk);
      bus_read(TOP + 1, v); chk("R9 held sec", v, 8'h42);
      bus_write(TOP, 8'h00);
      repeat (DIV + 1) @(posedge clk);
      bus_write(TOP, 8'h40);
      bus_read(TOP + 1, v); chk("R9 committed sec", v, 8'h43);
      bus_write(TOP, 8'h00);

      // R10 stop
      load_time({8'h25, 8'h03, 8'h10, 8'h01, 8'h10, 8'h00, 8'h10}, 8'h20);
      repeat (4 * DIV) @(posedge clk);
      bus_read(TOP + 1, v); chk("R10 stopped sec", v, 8'h10);
      bus_write(TOP, 8'h00);
      repeat (DIV + 1) @(posedge clk);
      bus_write(TOP, 8'h40);
      bus_read(TOP + 1, v); chk("R10 resumed sec", v, 8'h11);

      // R11 control readback
      bus_write(TOP, 8'h15);
      bus_read(TOP, v); chk("R11 ctrl readback", v, 8'h15);
      bus_write(TOP, 8'h00);

      // R3 writes blocked with power low
      pwr_ok = 0;
      bus_write(a_list[5], ~mdl[a_list[5]]);
      bus_write(TOP, 8'h80);
      bus_write(TOP + 7, 8'h55);
      pwr_ok = 1;
      bus_read(a_list[5], v); chk("R3 storage kept", v, mdl[a_list[5]]);
      bus_read(TOP, v);       chk("R3 ctrl kept", v, 8'h00);
      bus_write(TOP, 8'h40);
      bus_read(TOP + 7, v);   chk("R3 year kept", v, 8'h25);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule